// File: doc/BRIEF.md
# Skip-Based Rate Match FIFO

This block is an elastic buffer placed between a receive clock recovered from a serial line and the local clock of the receiver. The two clocks run at nominally equal rates, but they can differ by a small offset. Symbols enter on the recovered clock and leave on the local clock. Each symbol is a data byte plus a control flag. The buffer keeps its fill level near the middle by acting only on one configured skip symbol, which is a control-flagged code. When the buffer runs high, an incoming skip is discarded. When it runs low, an outgoing skip is sent twice. Packet data is never added or removed, because skip symbols only appear in idle stretches and in the gaps between packets.

Each side tracks the occupancy from its own pointer and from a gray-coded copy of the other side's pointer, carried across through a two-flop synchronizer. Each side shows its own limit: full on the write side and empty on the read side. A write made while full and a read requested while empty are both refused, and each one sets a sticky error bit. Every deletion and every insertion is reported by a one-cycle pulse in the domain where it happened.

Top module: `rate_match_fifo`

## Requirements
- R1: Every symbol that is accepted is delivered once, in write order, with its data and control flag unchanged. The only exception is a skip symbol that R3 repeats. `rd_valid` is high in the read cycle after each accepted read request.
- R2: Suppose the write-side occupancy is greater than `HI_MARK` when a skip symbol is presented. That symbol is then not stored, and `skip_del` pulses high for one write cycle in the cycle after it was presented.
- R3: Suppose the last symbol delivered was a skip and has not been repeated yet, and the read-side occupancy is below `LO_MARK` when a read is requested. The read pointer then holds, the same skip is delivered again, and `skip_ins` pulses high together with that repeated symbol.
- R4: A symbol counts as a skip only when `ctl` is 1 and the data equals `SKIP_CODE`. The default `SKIP_CODE` is 8'h1C. The same byte with `ctl` = 0 is ordinary data.
- R5: `full` is high while the write-side occupancy equals 2^`ADDR_W`. A write presented while `full` is high stores nothing.
- R6: `empty` is high while the read-side occupancy is 0. A read requested while `empty` is high, with no insertion pending, delivers nothing and leaves the read pointer unchanged.
- R7: `overflow` rises after a non-deleted write meets `full`. It stays high until write reset.
- R8: `underflow` rises after a read request meets `empty` with no insertion pending. It stays high until read reset.
- R9: The pointers cross domains in gray code, so only one bit changes per update. A pointer update reaches the opposite side's occupancy three edges of that side's clock later: one edge for the pointer register and two synchronizer edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Write-domain reset, active low, asynchronous |
| wr_en | input | 1 | A symbol is presented this cycle |
| wr_data | input | DATA_W | Incoming symbol data |
| wr_ctl | input | 1 | Incoming symbol control flag |
| full | output | 1 | Write-side occupancy at capacity |
| overflow | output | 1 | Sticky: a write was refused |
| skip_del | output | 1 | One-cycle pulse: a skip was dropped |
| rd_clk | input | 1 | Local clock |
| rd_rst_n | input | 1 | Read-domain reset, active low, asynchronous |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | A symbol is delivered this cycle |
| rd_data | output | DATA_W | Delivered symbol data |
| rd_ctl | output | 1 | Delivered symbol control flag |
| empty | output | 1 | Read-side occupancy is zero |
| underflow | output | 1 | Sticky: a read found nothing to deliver |
| skip_ins | output | 1 | One-cycle pulse: a skip was repeated |

## Verification
`rd_valid`, `rd_data`, `rd_ctl` and `skip_ins` change on the read edge that samples the request. `skip_del` and `overflow` change on the write edge that samples the symbol. `underflow` also changes on the edge that samples the request. `full` and `empty` follow their own side's pointer on the same edge, but they see a change to the opposite pointer only three edges after that pointer moved. The bench runs both domains on one 100 MHz clock. It keeps a queue-based model whose view of the opposite pointer goes through a three-entry delay line, updates the model on the rising edge and compares every output on the following falling edge, when no edge is near.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

  // Binary to reflected gray code.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray back to binary through a prefix XOR.
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 0; i < 5; i++) begin
      b = b ^ (b >> (32'd1 << i));
    end
    return b;
  endfunction

  // Number of entries between two wrapped pointers of the given width.
  function automatic logic [31:0] fill_level(input logic [31:0] head,
                                             input logic [31:0] tail,
                                             input int unsigned width);
    logic [31:0] diff;
    diff = head - tail;
    return diff & ((32'd1 << width) - 32'd1);
  endfunction

endpackage

// File: rtl/rmf_sync.sv
module rmf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rmf_mem.sv
module rmf_mem #(
  parameter int W      = 9,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rmf_wr_ctrl.sv
module rmf_wr_ctrl
  import rmf_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 4,
  parameter int                HI_MARK   = 12,
  parameter logic [DATA_W-1:0] SKIP_CODE = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ctl,
  input  logic [ADDR_W:0]   rptr_gray_s,
  output logic [ADDR_W:0]   wptr_bin,
  output logic [ADDR_W:0]   wptr_gray,
  output logic              mem_we,
  output logic              full,
  output logic              overflow,
  output logic              skip_del,
  output logic              drop_evt
);
  localparam int             PW      = ADDR_W + 1;
  localparam logic [PW-1:0]  DEPTH_L = PW'(1 << ADDR_W);
  localparam logic [PW-1:0]  HI_L    = PW'(HI_MARK);
  localparam logic [PW-1:0]  ONE_L   = PW'(1);

  logic [PW-1:0] rptr_seen;
  logic [PW-1:0] occ;
  logic [PW-1:0] wptr_nxt;
  logic          is_skip;
  logic          refused;

  always_comb begin
    rptr_seen = PW'(from_gray(32'(rptr_gray_s)));
    occ       = PW'(fill_level(32'(wptr_bin), 32'(rptr_seen), PW));
    full      = (occ == DEPTH_L);
    is_skip   = wr_ctl && (wr_data == SKIP_CODE);
    drop_evt  = wr_en && is_skip && (occ > HI_L);
    refused   = wr_en && !drop_evt && full;
    mem_we    = wr_en && !drop_evt && !full;
    wptr_nxt  = mem_we ? (wptr_bin + ONE_L) : wptr_bin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
      overflow  <= 1'b0;
      skip_del  <= 1'b0;
    end else begin
      wptr_bin  <= wptr_nxt;
      wptr_gray <= PW'(to_gray(32'(wptr_nxt)));
      overflow  <= overflow | refused;
      skip_del  <= drop_evt;
    end
  end
endmodule

// File: rtl/rmf_rd_ctrl.sv
module rmf_rd_ctrl
  import rmf_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 4,
  parameter int                LO_MARK   = 5,
  parameter logic [DATA_W-1:0] SKIP_CODE = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wptr_gray_s,
  input  logic [DATA_W:0]   mem_q,
  output logic [ADDR_W:0]   rptr_bin,
  output logic [ADDR_W:0]   rptr_gray,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ctl,
  output logic              empty,
  output logic              underflow,
  output logic              skip_ins,
  output logic              ins_evt
);
  localparam int            PW    = ADDR_W + 1;
  localparam logic [PW-1:0] LO_L  = PW'(LO_MARK);
  localparam logic [PW-1:0] ONE_L = PW'(1);

  logic [PW-1:0] wptr_seen;
  logic [PW-1:0] occ;
  logic [PW-1:0] rptr_nxt;
  logic          armed;
  logic          pop;
  logic          starve;
  logic          q_is_skip;

  always_comb begin
    wptr_seen = PW'(from_gray(32'(wptr_gray_s)));
    occ       = PW'(fill_level(32'(wptr_seen), 32'(rptr_bin), PW));
    empty     = (occ == '0);
    ins_evt   = rd_en && armed && (occ < LO_L);
    pop       = rd_en && !ins_evt && !empty;
    starve    = rd_en && !ins_evt && empty;
    q_is_skip = mem_q[DATA_W] && (mem_q[DATA_W-1:0] == SKIP_CODE);
    rptr_nxt  = pop ? (rptr_bin + ONE_L) : rptr_bin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_ctl    <= 1'b0;
      armed     <= 1'b0;
      underflow <= 1'b0;
      skip_ins  <= 1'b0;
    end else begin
      rptr_bin  <= rptr_nxt;
      rptr_gray <= PW'(to_gray(32'(rptr_nxt)));
      rd_valid  <= pop | ins_evt;
      skip_ins  <= ins_evt;
      underflow <= underflow | starve;
      if (pop) begin
        rd_data <= mem_q[DATA_W-1:0];
        rd_ctl  <= mem_q[DATA_W];
        armed   <= q_is_skip;
      end else if (ins_evt) begin
        armed   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rate_match_fifo.sv
module rate_match_fifo #(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 4,
  parameter int                HI_MARK   = 12,
  parameter int                LO_MARK   = 5,
  parameter logic [DATA_W-1:0] SKIP_CODE = 8'h1C
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ctl,
  output logic              full,
  output logic              overflow,
  output logic              skip_del,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ctl,
  output logic              empty,
  output logic              underflow,
  output logic              skip_ins
);
  localparam int PW = ADDR_W + 1;
  localparam int SW = DATA_W + 1;

  // Named internal events, observed by the bound checker.
  logic [PW-1:0] wptr_bin;
  logic [PW-1:0] wptr_gray;
  logic [PW-1:0] rptr_bin;
  logic [PW-1:0] rptr_gray;
  logic [PW-1:0] wptr_gray_rs;
  logic [PW-1:0] rptr_gray_ws;
  logic          mem_we;
  logic          drop_evt;
  logic          ins_evt;
  logic [SW-1:0] mem_q;

  rmf_wr_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HI_MARK(HI_MARK), .SKIP_CODE(SKIP_CODE)
  ) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ctl(wr_ctl), .rptr_gray_s(rptr_gray_ws), .wptr_bin(wptr_bin),
    .wptr_gray(wptr_gray), .mem_we(mem_we), .full(full),
    .overflow(overflow), .skip_del(skip_del), .drop_evt(drop_evt)
  );

  rmf_mem #(.W(SW), .ADDR_W(ADDR_W)) u_mem (
    .clk(wr_clk), .we(mem_we), .waddr(wptr_bin[ADDR_W-1:0]),
    .wdata({wr_ctl, wr_data}), .raddr(rptr_bin[ADDR_W-1:0]), .rdata(mem_q)
  );

  rmf_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wptr_gray), .q(wptr_gray_rs)
  );

  rmf_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rptr_gray), .q(rptr_gray_ws)
  );

  rmf_rd_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LO_MARK(LO_MARK), .SKIP_CODE(SKIP_CODE)
  ) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wptr_gray_s(wptr_gray_rs),
    .mem_q(mem_q), .rptr_bin(rptr_bin), .rptr_gray(rptr_gray),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ctl(rd_ctl), .empty(empty),
    .underflow(underflow), .skip_ins(skip_ins), .ins_evt(ins_evt)
  );
endmodule

// File: rtl/rmf_checker.sv
module rmf_checker #(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 4,
  parameter logic [DATA_W-1:0] SKIP_CODE = 8'h1C
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ctl,
  input logic              full,
  input logic              overflow,
  input logic              skip_del,
  input logic              drop_evt,
  input logic [ADDR_W:0]   wptr_bin,
  input logic [ADDR_W:0]   wptr_gray,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_ctl,
  input logic              empty,
  input logic              underflow,
  input logic              skip_ins,
  input logic              ins_evt,
  input logic [ADDR_W:0]   rptr_bin,
  input logic [ADDR_W:0]   rptr_gray
);
  a_r2_del_only_skip: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    skip_del |-> $past(wr_en && wr_ctl && (wr_data == SKIP_CODE)));

  a_r2_drop_no_store: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    drop_evt |=> $stable(wptr_bin));

  a_r5_full_blocks_write: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (full && wr_en && !drop_evt) |=> $stable(wptr_bin));

  a_r7_overflow_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    overflow |=> overflow);

  a_r7_overflow_cause: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $rose(overflow) |-> $past(full && wr_en));

  a_r9_wr_gray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  a_r3_ins_repeats_skip: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    skip_ins |-> (rd_valid && rd_ctl && (rd_data == SKIP_CODE) && $stable(rd_data)));

  a_r3_ins_holds_ptr: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    ins_evt |=> $stable(rptr_bin));

  a_r6_empty_blocks_read: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (empty && rd_en && !ins_evt) |=> ($stable(rptr_bin) && !rd_valid));

  a_r8_underflow_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    underflow |=> underflow);

  a_r9_rd_gray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);
endmodule

bind rate_match_fifo rmf_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SKIP_CODE(SKIP_CODE)
) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .wr_ctl(wr_ctl), .full(full), .overflow(overflow), .skip_del(skip_del),
  .drop_evt(drop_evt), .wptr_bin(wptr_bin), .wptr_gray(wptr_gray),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_ctl(rd_ctl), .empty(empty), .underflow(underflow),
  .skip_ins(skip_ins), .ins_evt(ins_evt), .rptr_bin(rptr_bin),
  .rptr_gray(rptr_gray)
);

// File: tb/rate_match_fifo_test.sv
module rate_match_fifo_test;
  localparam int         DW    = 8;
  localparam int         AW    = 4;
  localparam int         DEPTH = 1 << AW;
  localparam int         HI    = 12;
  localparam int         LO    = 5;
  localparam logic [7:0] SKIPV = 8'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_ctl = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic full, overflow, skip_del, rd_valid, rd_ctl, empty, underflow, skip_ins;
  logic [DW-1:0] rd_data;

  always #5 clk = ~clk;

  rate_match_fifo #(
    .DATA_W(DW), .ADDR_W(AW), .HI_MARK(HI), .LO_MARK(LO), .SKIP_CODE(SKIPV)
  ) uut (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ctl(wr_ctl), .full(full), .overflow(overflow), .skip_del(skip_del),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ctl(rd_ctl), .empty(empty), .underflow(underflow),
    .skip_ins(skip_ins)
  );

  // Behavioural reference model
  logic [DW:0] q[$];
  int wcnt, rcnt;
  int wpipe[$];
  int rpipe[$];
  logic e_valid, e_ins, e_del, e_ovf, e_udf, armed;
  logic [DW:0] e_sym;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic model_reset();
    q.delete(); wpipe = '{0, 0, 0}; rpipe = '{0, 0, 0};
    wcnt = 0; rcnt = 0; e_valid = 0; e_ins = 0; e_del = 0;
    e_ovf = 0; e_udf = 0; armed = 0; e_sym = '0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      int rseen, wseen, occ_w, occ_r;
      rseen = rpipe[0];
      wseen = wpipe[0];
      occ_w = wcnt - rseen;
      e_del = 0;
      if (wr_en) begin
        if (wr_ctl && wr_data == SKIPV && occ_w > HI) e_del = 1;
        else if (occ_w == DEPTH) e_ovf = 1;
        else begin q.push_back({wr_ctl, wr_data}); wcnt++; end
      end
      occ_r = wseen - rcnt;
      e_ins = 0;
      if (rd_en) begin
        if (armed && occ_r < LO) begin e_ins = 1; armed = 0; e_valid = 1; end
        else if (occ_r != 0) begin
          e_sym = q.pop_front(); rcnt++; e_valid = 1;
          armed = (e_sym == {1'b1, SKIPV});
        end else begin e_valid = 0; e_udf = 1; end
      end else e_valid = 0;
      wpipe.push_back(wcnt); void'(wpipe.pop_front());
      rpipe.push_back(rcnt); void'(rpipe.pop_front());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rd_valid === e_valid, "R1 rd_valid", int'(rd_valid), int'(e_valid));
      if (e_valid)
        chk({rd_ctl, rd_data} === e_sym, "R1 R4 symbol", int'({rd_ctl, rd_data}), int'(e_sym));
      chk(skip_ins === e_ins, "R3 skip_ins", int'(skip_ins), int'(e_ins));
      chk(skip_del === e_del, "R2 skip_del", int'(skip_del), int'(e_del));
      chk(full === ((wcnt - rpipe[0]) == DEPTH), "R5 R9 full", int'(full), int'((wcnt - rpipe[0]) == DEPTH));
      chk(empty === ((wpipe[0] - rcnt) == 0), "R6 R9 empty", int'(empty), int'((wpipe[0] - rcnt) == 0));
      chk(overflow === e_ovf, "R7 overflow", int'(overflow), int'(e_ovf));
      chk(underflow === e_udf, "R8 underflow", int'(underflow), int'(e_udf));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    wr_en = 0; rd_en = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic put(input logic c, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_ctl = c; wr_data = d;
  endtask

  task automatic idle_wr();
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic get_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rd_en = 1;
    end
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // Reset state: R6 empty high, R5 full low, no valid output
    @(negedge clk);
    chk(empty === 1'b1, "R6 reset empty", int'(empty), 1);
    chk(full === 1'b0, "R5 reset full", int'(full), 0);
    chk(rd_valid === 1'b0, "R1 reset valid", int'(rd_valid), 0);

    // Phase B: steady flow, mixed symbols incl. R4 look-alikes (ctl=0, 0x1C)
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          if (i % 6 == 5) put(1'b1, SKIPV);
          else if (i % 10 == 3) put(1'b0, SKIPV);
          else if (i % 10 == 7) put(1'b1, 8'hF7);
          else put(1'b0, 8'(i));
        end
        idle_wr();
      end
      begin
        repeat (8) @(negedge clk);
        get_cycles(70);
      end
    join
    repeat (4) @(negedge clk);

    // Phase C: fill without reading -> R2 deletions, R5 full, R7 overflow
    do_reset();
    for (int i = 0; i < 30; i++) begin
      if (i % 2 == 1) put(1'b1, SKIPV);
      else put(1'b0, 8'(i));
    end
    idle_wr();
    repeat (4) @(negedge clk);
    chk(overflow === 1'b1, "R7 overflow after fill", int'(overflow), 1);
    // Phase D: drain -> R3 insertions, R6 empty, R8 underflow
    get_cycles(25);
    repeat (3) @(negedge clk);
    chk(underflow === 1'b1, "R8 underflow after drain", int'(underflow), 1);

    // Phase E: slow writer, fast reader -> repeated insertions
    do_reset();
    fork
      begin
        for (int i = 0; i < 24; i++) begin
          if (i % 2 == 1) put(1'b1, SKIPV);
          else put(1'b0, 8'(8'h40 + i));
          idle_wr();
        end
      end
      begin
        repeat (4) @(negedge clk);
        get_cycles(60);
      end
    join
    repeat (6) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule